// File: doc/BRIEF.md
# CAN Transceiver Mode and Protection Controller

This block is the digital control core of a high-speed CAN transceiver. It decides when the bus driver may force the line dominant, where the bus common-mode bias sits, whether the split-termination bias output is on, and what is shown on the receive output. A mode pin selects between an active mode and a low-power standby mode. The transmit pin, the mode pin and both digitized bus indications are resynchronized to the local clock before use.

In active mode the driver follows the transmit input. A watchdog stops the driver when transmit is held dominant too long, so that a failed controller cannot block the network. In standby the driver is off and the bus is biased to ground. A filtered low-power receive path then reports a wake-up on the receive output only after the bus has stayed dominant past a programmable filter time. An over-temperature flag turns off the driver and the split bias. An undervoltage flag turns off the driver only. All times are parameters counted in clock cycles. The dominant time-out must be set longer than 11 bit times at the slowest bit rate in use.

Top module: `can_xcvr_ctrl`

## Requirements
- R1: During and after reset, with the transmit and mode inputs high, the block is in standby: drv_en_o=0, bias_mid_o=0, split_en_o=0, rxd_o=1. The synchronizers reset to transmit recessive (1) and mode standby (1).
- R2: With mode input high (standby), drv_en_o=0, bias_mid_o=0 (ground bias) and split_en_o=0. txd_i and bus_dom_i have no effect on any output.
- R3: With mode input low (active), bias_mid_o=1 and split_en_o=1. rxd_o is the inverse of bus_dom_i (1 = dominant) after a two-flop synchronizer. lp_dom_i has no effect.
- R4: drv_en_o is 1 only in active mode while the synchronized txd_i is low and no time-out, over-temperature or undervoltage is present.
- R5: A low pulse on txd_i lasting L cycles gives min(L, DOM_CYCLES) cycles of drv_en_o=1. The driver then stays off for the rest of the pulse.
- R6: Once txd_i has been seen high, the time-out is cleared, and a following short low pulse drives for its full length.
- R7: While a time-out is active, bias_mid_o=1 and split_en_o=1.
- R8: While ot_i=1 (unsynchronized), drv_en_o=0 and split_en_o=0. Driving resumes once ot_i clears.
- R9: While uv_i=1 (unsynchronized), drv_en_o=0, and bias_mid_o and split_en_o are unchanged.
- R10: In standby, a dominant pulse of L cycles on lp_dom_i (1 = dominant) gives max(0, L-WAKE_CYCLES) cycles of rxd_o=0. rxd_o returns to 1 in the same cycle the synchronized indication becomes recessive.
- R11: A mode change restarts both timers. After a return to active mode with txd_i still low, the driver runs for a full DOM_CYCLES. After a return to standby with lp_dom_i still dominant, a full WAKE_CYCLES filter applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| txd_i | input | 1 | Transmit data, low = dominant |
| stb_i | input | 1 | Mode select, high = standby |
| bus_dom_i | input | 1 | Main comparator, 1 = bus dominant |
| lp_dom_i | input | 1 | Low-power receiver, 1 = bus dominant |
| ot_i | input | 1 | Over-temperature flag |
| uv_i | input | 1 | Supply undervoltage flag |
| drv_en_o | output | 1 | Driver enable, 1 = drive dominant |
| bias_mid_o | output | 1 | Bias select, 1 = mid-supply, 0 = ground |
| split_en_o | output | 1 | Split bias output enable |
| rxd_o | output | 1 | Receive output, low = dominant or wake-up |

## Verification
The hardest states to reach are the ones where a timer is part way through its count and the mode changes underneath it. To show that the count restarts, the bench holds transmit low across a trip to standby and back, and holds the low-power indication dominant across a trip to active mode and back. It then checks the exact number of drive or wake-up cycles that follow. The time-out and the wake filter are also swept over every pulse length from one cycle to several cycles past the limit. The number of active output cycles is compared with min(L, DOM_CYCLES) and max(0, L-WAKE_CYCLES). This makes the result independent of synchronizer latency but exact in length.

// File: rtl/cxc_pkg.sv
package cxc_pkg;
  typedef enum logic {
    MODE_ACTIVE  = 1'b0,
    MODE_STANDBY = 1'b1
  } mode_e;

  typedef struct packed {
    logic lp_dom;
    logic bus_dom;
    logic stb;
    logic txd;
  } pins_t;

  localparam int unsigned PIN_W = $bits(pins_t);
  // recessive txd, standby mode, idle bus
  localparam pins_t PIN_RST = '{lp_dom: 1'b0, bus_dom: 1'b0, stb: 1'b1, txd: 1'b1};
endpackage

// File: rtl/cxc_sync.sv
module cxc_sync #(
  parameter int unsigned WIDTH   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else if (s == 0) stage_q[s] <= d_i;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cxc_dom_timer.sv
module cxc_dom_timer #(
  parameter int unsigned DOM_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic dom_i,
  output logic timeout_o
);
  localparam int unsigned CW = $clog2(DOM_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(DOM_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          to_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (clr_i || !dom_i) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else if (!to_q) begin
      if (cnt_q == LAST) to_q <= 1'b1;
      else cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout_o = to_q;
endmodule

// File: rtl/cxc_wake_filter.sv
module cxc_wake_filter #(
  parameter int unsigned WAKE_CYCLES = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic dom_i,
  output logic wake_o
);
  localparam int unsigned CW = $clog2(WAKE_CYCLES + 1);
  localparam logic [CW-1:0] FULL = CW'(WAKE_CYCLES);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (clr_i || !dom_i) cnt_q <= '0;
    else if (cnt_q != FULL) cnt_q <= cnt_q + 1'b1;
  end

  // drops as soon as the bus goes recessive
  assign wake_o = dom_i && (cnt_q == FULL);
endmodule

// File: rtl/can_xcvr_ctrl.sv
module can_xcvr_ctrl
  import cxc_pkg::*;
#(
  parameter int unsigned DOM_CYCLES  = 8,
  parameter int unsigned WAKE_CYCLES = 5,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic txd_i,
  input  logic stb_i,
  input  logic bus_dom_i,
  input  logic lp_dom_i,
  input  logic ot_i,
  input  logic uv_i,
  output logic drv_en_o,
  output logic bias_mid_o,
  output logic split_en_o,
  output logic rxd_o
);
  pins_t pins_raw, pins_s;
  mode_e mode;
  logic  standby, timeout, wake;

  assign pins_raw = '{lp_dom: lp_dom_i, bus_dom: bus_dom_i, stb: stb_i, txd: txd_i};

  cxc_sync #(
    .WIDTH  (PIN_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(PIN_RST)
  ) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pins_raw),
    .q_o   (pins_s)
  );

  assign mode    = pins_s.stb ? MODE_STANDBY : MODE_ACTIVE;
  assign standby = (mode == MODE_STANDBY);

  cxc_dom_timer #(.DOM_CYCLES(DOM_CYCLES)) i_dom_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clr_i    (standby),
    .dom_i    (!pins_s.txd),
    .timeout_o(timeout)
  );

  cxc_wake_filter #(.WAKE_CYCLES(WAKE_CYCLES)) i_wake_filter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!standby),
    .dom_i (pins_s.lp_dom),
    .wake_o(wake)
  );

  assign drv_en_o   = !standby && !pins_s.txd && !timeout && !ot_i && !uv_i;
  assign bias_mid_o = !standby;
  assign split_en_o = !standby && !ot_i;
  assign rxd_o      = standby ? !wake : !pins_s.bus_dom;
endmodule

// File: rtl/cxc_checker.sv
module cxc_checker #(
  parameter int unsigned DOM_CYCLES = 8
) (
  input logic clk_i,
  input logic rst_ni,
  input logic ot_i,
  input logic uv_i,
  input logic drv_en_o,
  input logic bias_mid_o,
  input logic split_en_o
);
  localparam int unsigned CW = $clog2(DOM_CYCLES + 2);
  localparam logic [CW-1:0] CAP = CW'(DOM_CYCLES + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) run_q <= '0;
    else if (!drv_en_o) run_q <= '0;
    else if (run_q != CAP) run_q <= run_q + 1'b1;
  end

  AST_STBY_NO_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bias_mid_o |-> (!drv_en_o && !split_en_o)); // R2
  AST_DRIVE_BIASED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drv_en_o |-> bias_mid_o); // R4
  AST_DRIVE_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= CW'(DOM_CYCLES)); // R5
  AST_OT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ot_i |-> (!drv_en_o && !split_en_o)); // R8
  AST_UV_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    uv_i |-> !drv_en_o); // R9
endmodule

bind can_xcvr_ctrl cxc_checker #(.DOM_CYCLES(DOM_CYCLES)) i_cxc_checker (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ot_i      (ot_i),
  .uv_i      (uv_i),
  .drv_en_o  (drv_en_o),
  .bias_mid_o(bias_mid_o),
  .split_en_o(split_en_o)
);

// File: tb/test_can_xcvr_ctrl.sv
`timescale 1ns/1ps
module test_can_xcvr_ctrl;
  localparam int DOM  = 8;
  localparam int WAKE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, stb = 1'b1, bus_dom = 1'b0, lp_dom = 1'b0, ot = 1'b0, uv = 1'b0;
  logic drv_en, bias_mid, split_en, rxd;
  int   n_chk = 0, n_err = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  can_xcvr_ctrl #(.DOM_CYCLES(DOM), .WAKE_CYCLES(WAKE), .SYNC_STAGES(2)) i_can_xcvr_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .txd_i(txd), .stb_i(stb), .bus_dom_i(bus_dom),
    .lp_dom_i(lp_dom), .ot_i(ot), .uv_i(uv), .drv_en_o(drv_en), .bias_mid_o(bias_mid),
    .split_en_o(split_en), .rxd_o(rxd)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // sel 0: txd low pulse, count drv_en high; 1: bus_dom pulse, count rxd low;
  // 2: lp_dom pulse, count rxd low
  task automatic pulse(input int sel, input int len, input int win, output int cnt);
    cnt = 0;
    @(negedge clk);
    case (sel)
      0: txd = 1'b0;
      1: bus_dom = 1'b1;
      default: lp_dom = 1'b1;
    endcase
    for (int i = 1; i <= win; i++) begin
      @(posedge clk); #1;
      if (sel == 0 ? drv_en : !rxd) cnt++;
      if (i == len) begin
        case (sel)
          0: txd = 1'b1;
          1: bus_dom = 1'b0;
          default: lp_dom = 1'b0;
        endcase
      end
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    int c;
    // R1 reset state
    #23;
    chk("R1 drv", drv_en, 0); chk("R1 bias", bias_mid, 0);
    chk("R1 split", split_en, 0); chk("R1 rxd", rxd, 1);
    rst_n = 1'b1;
    idle(4);
    chk("R1 drv post", drv_en, 0); chk("R1 bias post", bias_mid, 0);
    chk("R1 rxd post", rxd, 1);

    // R2 standby ignores txd and bus_dom
    pulse(0, DOM + 4, DOM + 10, c); chk("R2 txd ignored", c, 0);
    pulse(1, 4, 10, c);             chk("R2 bus ignored", c, 0);
    chk("R2 split", split_en, 0);

    // R10 wake filter sweep
    for (int l = 1; l <= WAKE + 4; l++) begin
      pulse(2, l, l + 6, c);
      chk("R10 wake", c, (l > WAKE) ? l - WAKE : 0);
      chk("R10 rxd released", rxd, 1);
    end

    // R3 active mode
    stb = 1'b0; idle(4);
    chk("R3 bias", bias_mid, 1); chk("R3 split", split_en, 1);
    chk("R3 rxd idle", rxd, 1); chk("R4 drv idle", drv_en, 0);
    for (int l = 1; l <= 4; l++) begin
      pulse(1, l, l + 6, c); chk("R3 rxd follows", c, l);
    end
    pulse(2, WAKE + 3, WAKE + 8, c); chk("R3 lp ignored", c, 0);

    // R4/R5 time-out sweep
    for (int l = 1; l <= DOM + 4; l++) begin
      pulse(0, l, l + 6, c);
      chk("R5 drive len", c, (l < DOM) ? l : DOM);
    end
    // R6 recovery after long pulse
    pulse(0, 3, 9, c); chk("R6 recovered", c, 3);

    // R7 bias during time-out
    @(negedge clk); txd = 1'b0;
    idle(DOM + 5);
    chk("R7 drv off", drv_en, 0); chk("R7 bias", bias_mid, 1); chk("R7 split", split_en, 1);
    txd = 1'b1; idle(4);

    // R8 over-temperature
    ot = 1'b1; #1;
    chk("R8 split off", split_en, 0);
    pulse(0, 3, 9, c); chk("R8 no drive", c, 0);
    ot = 1'b0; #1;
    chk("R8 split back", split_en, 1);
    pulse(0, 3, 9, c); chk("R8 resumes", c, 3);

    // R9 undervoltage
    uv = 1'b1; #1;
    pulse(0, 3, 9, c); chk("R9 no drive", c, 0);
    chk("R9 split kept", split_en, 1); chk("R9 bias kept", bias_mid, 1);
    uv = 1'b0; #1;

    // R11 time-out restarts across a standby trip
    @(negedge clk); txd = 1'b0;
    idle(DOM - 2);
    stb = 1'b1; idle(6);
    chk("R11 standby drv", drv_en, 0);
    @(negedge clk); stb = 1'b0;
    c = 0;
    for (int i = 1; i <= DOM + 12; i++) begin
      @(posedge clk); #1;
      if (drv_en) c++;
    end
    chk("R11 full timeout", c, DOM);
    txd = 1'b1; idle(4);

    // R11 wake filter restarts across an active trip
    stb = 1'b1; idle(4);
    @(negedge clk); lp_dom = 1'b1;
    idle(WAKE - 2);
    @(negedge clk); stb = 1'b0;
    idle(6);
    @(negedge clk); stb = 1'b1;
    c = 0;
    for (int i = 1; i <= WAKE + 12; i++) begin
      @(posedge clk); #1;
      if (!rxd) c++;
    end
    chk("R11 full filter", c, 11);
    lp_dom = 1'b0; idle(4);
    chk("R10 rxd high", rxd, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule